// File: doc/BRIEF.md
# Interpolating Function Lookup Table

This block evaluates an arbitrary precomputed function of a 16-bit unsigned operand. The result is not limited to 256 coarse steps. The block keeps 256 sample points of the function in on-chip storage, fetches the two samples that bracket the operand, and blends them linearly according to the operand's low byte. The result has close to 15 bits of effective resolution, where a plain 256-entry lookup gives 8.

It accepts one operand per clock, qualified by a valid flag, and returns one result per operand after a fixed latency of three clocks. That latency does not depend on the operand value. A separate write port replaces single table entries while the block keeps running. The surrounding system is expected to use that port during blanking intervals. The pipeline is built so that a write never corrupts a result whose samples have already been fetched.

Top module: `interp_lut`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, valid_o is 0 and result_o is 0.
- R2: An operand presented with valid_i high is sampled at a rising edge. Its result appears with valid_o high after the third rising edge, counting the sampling edge. Operands may arrive on every cycle. valid_o is low in every cycle that does not correspond to a valid operand.
- R3: Operand bits [15:8] form the sample index i, and bits [7:0] form the fraction f. When f is 0, the result equals entry i exactly.
- R4: The result is e[i] + floor(((e[i+1] - e[i]) * f) / 256), computed with signed differences. This makes decreasing segments interpolate correctly, including a full-scale step from 0xFFFF down to 0.
- R5: Every result lies between e[i] and e[i+1], inclusive.
- R6: For index 255 the upper neighbour is entry 255 itself. The result is then entry 255 for every fraction.
- R7: When wr_en_i is high at a rising edge, wr_data_i is stored into entry wr_addr_i at that edge. Any operand whose samples are fetched at a later edge uses the new value.
- R8: Samples are fetched at the second edge after the operand is sampled. A write landing on that same edge, or on any later edge, leaves that operand's result unchanged.
- R9: When valid_o is low, result_o holds the last valid result. Operand values presented with valid_i low do not affect the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand qualifier |
| operand_i | input | 16 | Operand: [15:8] sample index, [7:0] fraction |
| wr_en_i | input | 1 | Table write enable |
| wr_addr_i | input | 8 | Entry to write |
| wr_data_i | input | 16 | Value to store |
| valid_o | output | 1 | Result qualifier |
| result_o | output | 16 | Interpolated result |

## Verification
The latency property compares valid_o with valid_i from three cycles earlier. It therefore assumes that valid_i is driven to a known 0 throughout reset, and the stimulus does so from time zero. The range, zero-fraction and flat-segment properties take their bracketing samples from the values latched in the fetch stage. They need no assumption about when the write port is used. For this reason the random stimulus mixes table writes freely into the operand stream, at any distance from the operands it affects. Directed sequences place a write on the operand's own sampling edge and on its fetch edge, to pin down the write-versus-fetch ordering.

// File: rtl/interp_lut_pkg.sv
`timescale 1ns/1ps
package interp_lut_pkg;
  typedef enum logic {
    BANK_EVEN = 1'b0,
    BANK_ODD  = 1'b1
  } bank_e;
endpackage

// File: rtl/interp_lut_addr.sv
`timescale 1ns/1ps
// Stage 1: split operand, form bank read addresses for entries i and i+1.
module interp_lut_addr #(
  parameter int IDX_W  = 8,
  parameter int FRAC_W = 8,
  localparam int OP_W   = IDX_W + FRAC_W,
  localparam int ADDR_W = IDX_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   operand_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] even_addr_o,
  output logic [ADDR_W-1:0] odd_addr_o,
  output logic              odd_first_o,
  output logic              clamp_o,
  output logic [FRAC_W-1:0] frac_o
);
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] half;

  assign idx  = operand_i[OP_W-1 -: IDX_W];
  assign half = idx[IDX_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      even_addr_o <= '0;
      odd_addr_o  <= '0;
      odd_first_o <= 1'b0;
      clamp_o     <= 1'b0;
      frac_o      <= '0;
    end else begin
      valid_o     <= valid_i;
      // odd i: i+1 lives in the next even slot
      even_addr_o <= idx[0] ? half + ADDR_W'(1) : half;
      odd_addr_o  <= half;
      odd_first_o <= idx[0];
      clamp_o     <= &idx;
      frac_o      <= operand_i[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/interp_lut_bank.sv
`timescale 1ns/1ps
// One half of the table; registered read returns pre-write content.
module interp_lut_bank #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/interp_lut_blend.sv
`timescale 1ns/1ps
// Stage 3: lo + floor((hi - lo) * frac / 2^FRAC_W), registered.
module interp_lut_blend #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8,
  localparam int PROD_W = DATA_W + FRAC_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  logic signed [DATA_W:0]   diff;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] step;
  logic signed [PROD_W-1:0] sum;

  always_comb begin
    diff = $signed({1'b0, hi_i}) - $signed({1'b0, lo_i});
    prod = PROD_W'(diff) * PROD_W'($signed({1'b0, frac_i}));
    step = prod >>> FRAC_W;
    sum  = PROD_W'($signed({1'b0, lo_i})) + step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= DATA_W'(sum);
    end
  end

  assert_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (($past(lo_i) <= $past(hi_i))
                 ? (result_o >= $past(lo_i) && result_o <= $past(hi_i))
                 : (result_o <= $past(lo_i) && result_o >= $past(hi_i))));

  assert_frac_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(frac_i) == '0) |-> result_o == $past(lo_i));

  // clamped index presents equal samples: output must be flat (R6)
  assert_flat_segment_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(lo_i) == $past(hi_i)) |-> result_o == $past(lo_i));
endmodule

// File: rtl/interp_lut.sv
`timescale 1ns/1ps
module interp_lut #(
  parameter int IDX_W  = 8,
  parameter int FRAC_W = 8,
  parameter int DATA_W = 16,
  localparam int OP_W   = IDX_W + FRAC_W,
  localparam int ADDR_W = IDX_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   operand_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  import interp_lut_pkg::*;

  logic              s1_valid, s1_odd_first, s1_clamp;
  logic [ADDR_W-1:0] s1_even_addr, s1_odd_addr;
  logic [FRAC_W-1:0] s1_frac;

  logic              s2_valid, s2_odd_first, s2_clamp;
  logic [FRAC_W-1:0] s2_frac;
  logic [DATA_W-1:0] bank_rdata [2];
  logic [DATA_W-1:0] seg_lo, seg_hi;

  interp_lut_addr #(.IDX_W(IDX_W), .FRAC_W(FRAC_W)) i_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_i),
    .operand_i   (operand_i),
    .valid_o     (s1_valid),
    .even_addr_o (s1_even_addr),
    .odd_addr_o  (s1_odd_addr),
    .odd_first_o (s1_odd_first),
    .clamp_o     (s1_clamp),
    .frac_o      (s1_frac)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    localparam bank_e SEL = bank_e'(g);
    interp_lut_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && (bank_e'(wr_addr_i[0]) == SEL)),
      .waddr_i (wr_addr_i[IDX_W-1:1]),
      .wdata_i (wr_data_i),
      .raddr_i ((SEL == BANK_ODD) ? s1_odd_addr : s1_even_addr),
      .rdata_o (bank_rdata[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_valid     <= 1'b0;
      s2_odd_first <= 1'b0;
      s2_clamp     <= 1'b0;
      s2_frac      <= '0;
    end else begin
      s2_valid     <= s1_valid;
      s2_odd_first <= s1_odd_first;
      s2_clamp     <= s1_clamp;
      s2_frac      <= s1_frac;
    end
  end

  always_comb begin
    seg_lo = s2_odd_first ? bank_rdata[BANK_ODD] : bank_rdata[BANK_EVEN];
    if (s2_clamp)          seg_hi = bank_rdata[BANK_ODD];
    else if (s2_odd_first) seg_hi = bank_rdata[BANK_EVEN];
    else                   seg_hi = bank_rdata[BANK_ODD];
  end

  interp_lut_blend #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) i_blend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (s2_valid),
    .lo_i     (seg_lo),
    .hi_i     (seg_hi),
    .frac_i   (s2_frac),
    .valid_o  (valid_o),
    .result_o (result_o)
  );

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i, 3));

  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));
endmodule

// File: tb/test_interp_lut.sv
`timescale 1ns/1ps
module test_interp_lut;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] operand_i = '0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        valid_o;
  logic [15:0] result_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] tbl [256];
  logic        pv [3];
  logic [15:0] pe [3];
  string       pt [3];
  logic [15:0] last_res = '0;

  always #5 clk_i = ~clk_i;

  interp_lut i_interp_lut (
    .clk_i, .rst_ni, .valid_i, .operand_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .valid_o, .result_o
  );

  function automatic logic [15:0] model(input logic [15:0] op);
    int i, f, lo, hi, p;
    i  = int'(op[15:8]);
    f  = int'(op[7:0]);
    lo = int'(tbl[i]);
    hi = (i == 255) ? int'(tbl[255]) : int'(tbl[i+1]);
    p  = (hi - lo) * f;
    return 16'(lo + (p >>> 8));
  endfunction

  function automatic logic [15:0] init_val(input int i);
    return 16'((i * i * 37) ^ (i << 7));
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h (valid_o=%b) expected %h", req, act, valid_o, exp);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] op, input logic we,
                      input logic [7:0] wa, input logic [15:0] wd, input string tag);
    @(negedge clk_i);
    if (pv[2]) begin
      check(valid_o === 1'b1 && result_o === pe[2], pt[2], result_o, pe[2]);
      last_res = pe[2];
    end else begin
      check(valid_o === 1'b0 && result_o === last_res, "R2/R9 idle", result_o, last_res);
    end
    pv[2] = pv[1]; pe[2] = pe[1]; pt[2] = pt[1];
    pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
    wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
    if (we) tbl[wa] = wd;
    valid_i = v; operand_i = op;
    pv[0] = v; pe[0] = v ? model(op) : 16'h0; pt[0] = tag;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 16'($urandom), 1'b0, 8'h0, 16'h0, "R9");
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    step(1'b0, 16'h0, 1'b1, a, d, "R7");
  endtask

  initial begin
    void'($urandom(32'h5eed_1a2b));
    for (int k = 0; k < 3; k++) begin pv[k] = 1'b0; pe[k] = '0; pt[k] = ""; end
    for (int k = 0; k < 256; k++) tbl[k] = '0;
    repeat (3) @(negedge clk_i);
    check(valid_o === 1'b0 && result_o === 16'h0, "R1 in reset", result_o, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(valid_o === 1'b0 && result_o === 16'h0, "R1 after reset", result_o, 16'h0);

    for (int k = 0; k < 256; k++) wr(8'(k), init_val(k));
    idle(3);

    // R3: zero fraction returns the entry, odd and even indices
    step(1'b1, 16'h2000, 1'b0, 0, 0, "R3 even");
    step(1'b1, 16'h3300, 1'b0, 0, 0, "R3 odd");
    // R6: clamp at the top index
    step(1'b1, 16'hFFFF, 1'b0, 0, 0, "R6 frac ff");
    step(1'b1, 16'hFF80, 1'b0, 0, 0, "R6 frac 80");
    idle(3);

    // R4: full-scale falling and rising segments
    wr(8'd10, 16'hFFFF); wr(8'd11, 16'h0000); wr(8'd12, 16'hFFFF);
    step(1'b1, 16'h0AFF, 1'b0, 0, 0, "R4 falling");   // 0x00FF
    step(1'b1, 16'h0B01, 1'b0, 0, 0, "R4 rising");
    step(1'b1, 16'h0A80, 1'b0, 0, 0, "R4 mid");
    idle(3);

    // R7/R8: write ordering around the fetch edge
    wr(8'd40, 16'd100); wr(8'd41, 16'd200);
    step(1'b1, 16'h2880, 1'b0, 0, 0, "R8 pre-write");          // 150
    step(1'b0, 16'h0, 1'b1, 8'd41, 16'd1000, "R8");            // lands on fetch edge
    step(1'b0, 16'h0, 1'b1, 8'd40, 16'd7, "R8");               // later edge
    idle(2);
    step(1'b1, 16'h2880, 1'b1, 8'd40, 16'd0, "R7 same-edge");  // 500
    step(1'b1, 16'h2880, 1'b0, 0, 0, "R7 new value");
    idle(3);

    // R9: garbage operands with valid low
    for (int k = 0; k < 8; k++) step(1'b0, 16'($urandom), 1'b0, 0, 0, "R9");

    // Random mix: R2 throughput, R4/R5 values, R7 writes in flight
    for (int k = 0; k < 4000; k++) begin
      logic v, we;
      v  = ($urandom % 4) != 0;
      we = ($urandom % 20) == 0;
      step(v, 16'($urandom), we, 8'($urandom), 16'($urandom), "R4/R5 random");
    end
    // back-to-back burst
    for (int k = 0; k < 64; k++) step(1'b1, 16'($urandom), 1'b0, 0, 0, "R2 burst");
    idle(4);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule